// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt pin. It brings every pin into the system clock domain, then qualifies each interrupt pin against a sense mode that software selects per line: low level, falling edge, rising edge or both edges. A qualifying event sets a pending bit for that line. Each pending bit drives one request line toward a parent interrupt controller, and the pending bit stays set until software clears it. The parent controller does the masking, prioritising and vectoring, so none of that is in this block.

The non-maskable pin has its own edge selector (falling or rising) and a request flag. Its synchronised level can be read back directly. Software uses a 16-bit register bus with a write strobe. Reads are combinational from the address. A pending request is cleared by writing zero to its bit while writing ones to every other bit, so one write can clear one line without disturbing the others.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset, all pending bits and `irq_out` are 0, the sense register reads 0 (every line in low-level mode), the NMI edge select and NMI flag are 0, and the synchronisers hold the idle-high level.
- R2: The sense register at offset 2 is fully writable and readable. Line n uses bits [2n+1:2n], with the codes 0 = low level, 1 = falling edge, 2 = rising edge and 3 = both edges.
- R3: In falling-edge mode, a high-to-low pin transition sets the line's pending bit, and it becomes visible on the third rising clock edge after the pin change. A low-to-high transition sets nothing.
- R4: In rising-edge mode, only a low-to-high pin transition sets the pending bit, with the same three-edge latency.
- R5: In both-edges mode, either transition sets the pending bit.
- R6: In low-level mode, the pending bit is set on every cycle in which the synchronised pin is low. A clear issued while the pin is still low has no lasting effect, and the pending bit stays set after the pin returns high until software clears it.
- R7: The request register at offset 4 shows the pending bits in [7:0] and reads 0 in [15:8]. Writing 0 to a bit clears that request, writing 1 leaves it unchanged, and a new event in the same cycle as a clear wins.
- R8: `irq_out[n]` equals pending bit n in every cycle. A pending bit with no clear stays set.
- R9: Bit 15 of the control register at offset 0 is read-only and shows the NMI pin level two clock edges after the pin changes.
- R10: Bit 8 of offset 0 selects the NMI edge (0 = falling, 1 = rising). Bit 1 is the NMI flag, set three clock edges after the selected edge. The other edge does not set it.
- R11: Writing 0 to bit 1 of offset 0 clears the NMI flag, and writing 1 has no effect on it. If an NMI event lands in the same cycle as a clear, the flag remains set.
- R12: Unmapped offsets read 0 and ignore writes. The bits of offset 0 other than 15, 8 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | External interrupt pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| bus_addr | input | 3 | Register byte offset |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 8 | Per-line request toward the parent controller |

## Verification
A pin change driven just after a clock edge reaches the second synchroniser flop on the second following edge. The NMI level bit is therefore due after two edges, and pending bits, `irq_out` and the NMI flag are due after three. Register writes take effect on the edge that samples the strobe, and reads are valid as soon as the address settles. The bench drives every input on the falling clock edge and counts falling edges before it samples. Each latency check reads the result one edge early and again on the due edge, so a design that responds early or late fails. The same-cycle races (clear against a new event) are lined up by issuing the write strobe on exactly the edge at which the event lands.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // byte offsets of the three registers
  localparam int OFS_CTRL0 = 0;
  localparam int OFS_CTRL1 = 2;
  localparam int OFS_REQ   = 4;

  // control register 0 fields (the NMI level bit is the top bit)
  localparam int NMI_FLAG_BIT = 1;
  localparam int NMI_EDGE_BIT = 8;

  // qualify one synchronised line against its sense mode
  function automatic logic sense_hit(input sense_e mode, input logic cur, input logic prev);
    logic hit;
    case (mode)
      SENSE_LOW:  hit = ~cur;
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      default:    hit = prev ^ cur;
    endcase
    return hit;
  endfunction

  // NMI edge qualification: rising selects low-to-high, else high-to-low
  function automatic logic nmi_hit(input logic rising, input logic cur, input logic prev);
    return rising ? (~prev & cur) : (prev & ~cur);
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   WIDTH     = 9,
  parameter int   STAGES    = 2,
  parameter logic RESET_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {(STAGES*WIDTH){RESET_BIT}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       pend,
  output logic       set_evt,
  output logic       prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  assign set_evt = sense_hit(sense_e'(sense), lvl, prev);

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~clr) | set_evt;
  end

endmodule

// File: rtl/extint_nmi.sv
module extint_nmi
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_rise,
  input  logic clr,
  output logic flag,
  output logic evt
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  assign evt = nmi_hit(edge_rise, lvl, prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | evt;
  end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wen,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0]     pend,
  input  logic                   nmi_flag,
  input  logic                   nmi_lvl,
  output logic [2*NUM_IRQ-1:0]   sense_vec,
  output logic                   nmi_edge_rise,
  output logic [NUM_IRQ-1:0]     req_clr,
  output logic                   nmi_clr
);

  localparam int SENSE_W     = 2 * NUM_IRQ;
  localparam int NMI_LVL_BIT = DATA_W - 1;

  logic sel_ctrl0, sel_ctrl1, sel_req;

  assign sel_ctrl0 = (bus_addr == ADDR_W'(OFS_CTRL0));
  assign sel_ctrl1 = (bus_addr == ADDR_W'(OFS_CTRL1));
  assign sel_req   = (bus_addr == ADDR_W'(OFS_REQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_vec     <= '0;
      nmi_edge_rise <= 1'b0;
    end else if (bus_wen) begin
      if (sel_ctrl1) sense_vec     <= bus_wdata[SENSE_W-1:0];
      if (sel_ctrl0) nmi_edge_rise <= bus_wdata[NMI_EDGE_BIT];
    end
  end

  // clear-by-zero: a zero written to a bit is the clear request for that bit
  assign req_clr = (bus_wen && sel_req) ? ~bus_wdata[NUM_IRQ-1:0] : '0;
  assign nmi_clr = bus_wen && sel_ctrl0 && !bus_wdata[NMI_FLAG_BIT];

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl0) begin
      bus_rdata[NMI_LVL_BIT]  = nmi_lvl;
      bus_rdata[NMI_EDGE_BIT] = nmi_edge_rise;
      bus_rdata[NMI_FLAG_BIT] = nmi_flag;
    end else if (sel_ctrl1) begin
      bus_rdata = DATA_W'(sense_vec);
    end else if (sel_req) begin
      bus_rdata = DATA_W'(pend);
    end
  end

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic               nmi_pin,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wen,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_IRQ-1:0] irq_out
);

  localparam int PIN_W   = NUM_IRQ + 1;
  localparam int SENSE_W = 2 * NUM_IRQ;

  // named internal events, also watched by the bound checker
  logic [PIN_W-1:0]   sync_lvl;
  logic [NUM_IRQ-1:0] lvl_sync;
  logic [NUM_IRQ-1:0] lvl_prev;
  logic [NUM_IRQ-1:0] set_evt;
  logic [NUM_IRQ-1:0] pend;
  logic [NUM_IRQ-1:0] req_clr;
  logic [SENSE_W-1:0] sense_vec;
  logic               nmi_lvl;
  logic               nmi_evt;
  logic               nmi_clr;
  logic               nmi_flag;
  logic               nmi_edge_rise;

  extint_sync #(
    .WIDTH     (PIN_W),
    .STAGES    (SYNC_STAGES),
    .RESET_BIT (1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({nmi_pin, irq_pin}),
    .dout (sync_lvl)
  );

  assign lvl_sync = sync_lvl[NUM_IRQ-1:0];
  assign nmi_lvl  = sync_lvl[NUM_IRQ];

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    extint_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_sync[n]),
      .sense  (sense_vec[2*n +: 2]),
      .clr    (req_clr[n]),
      .pend   (pend[n]),
      .set_evt(set_evt[n]),
      .prev   (lvl_prev[n])
    );
  end

  extint_nmi u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (nmi_lvl),
    .edge_rise(nmi_edge_rise),
    .clr      (nmi_clr),
    .flag     (nmi_flag),
    .evt      (nmi_evt)
  );

  extint_regs #(
    .NUM_IRQ(NUM_IRQ),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wen      (bus_wen),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pend         (pend),
    .nmi_flag     (nmi_flag),
    .nmi_lvl      (nmi_lvl),
    .sense_vec    (sense_vec),
    .nmi_edge_rise(nmi_edge_rise),
    .req_clr      (req_clr),
    .nmi_clr      (nmi_clr)
  );

  assign irq_out = pend;

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_IRQ-1:0]   irq_out,
  input logic [NUM_IRQ-1:0]   set_evt,
  input logic [NUM_IRQ-1:0]   lvl_sync,
  input logic [NUM_IRQ-1:0]   lvl_prev,
  input logic [2*NUM_IRQ-1:0] sense_vec,
  input logic [NUM_IRQ-1:0]   req_clr,
  input logic                 nmi_evt,
  input logic                 nmi_clr,
  input logic                 nmi_flag
);

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_chk
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_clr[n] && !set_evt[n] |=> !irq_out[n]);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[n] && !req_clr[n] |=> irq_out[n]);

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[n] |=> irq_out[n]);

    // R5
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[n] && (sense_vec[2*n +: 2] != 2'd0) |-> (lvl_sync[n] != lvl_prev[n]));

    // R6
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vec[2*n +: 2] == 2'd0) && !lvl_sync[n] |-> set_evt[n]);
  end

  // R11
  nmi_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> nmi_flag);

  // R11
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_clr && !nmi_evt |=> !nmi_flag);

  // R10
  nmi_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_flag) |-> $past(nmi_evt));

endmodule

bind extint_sense_ctrl extint_sense_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .set_evt  (set_evt),
  .lvl_sync (lvl_sync),
  .lvl_prev (lvl_prev),
  .sense_vec(sense_vec),
  .req_clr  (req_clr),
  .nmi_evt  (nmi_evt),
  .nmi_clr  (nmi_clr),
  .nmi_flag (nmi_flag)
);

// File: tb/extint_sense_ctrl_tb_top.sv
module extint_sense_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_pin;
  logic        nmi_pin;
  logic [2:0]  bus_addr;
  logic        bus_wen;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pin  (irq_pin),
    .nmi_pin  (nmi_pin),
    .bus_addr (bus_addr),
    .bus_wen  (bus_wen),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    bus_addr  = 3'(a);
    bus_wdata = d;
    bus_wen   = 1'b1;
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic expect_reg(input string req, input int a, input logic [15:0] exp);
    logic [15:0] d;
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
    check(req, $sformatf("reg@%0d", a), d, exp);
  endtask

  task automatic expect_irq(input string req, input logic [7:0] exp);
    check(req, "irq_out", {8'h00, irq_out}, {8'h00, exp});
  endtask

  // R1, R9: idle state after reset
  task automatic t_reset();
    expect_reg("R1", 4, 16'h0000);
    expect_reg("R1", 2, 16'h0000);
    expect_reg("R9", 0, 16'h8000);
    expect_irq("R1", 8'h00);
  endtask

  // R2: sense register write/readback, then working modes
  task automatic t_sense();
    bus_write(2, 16'hA5C3);
    expect_reg("R2", 2, 16'hA5C3);
    // line0 low, line1 falling, line2 rising, line3 both, lines 4..7 low
    bus_write(2, 16'h00E4);
    expect_reg("R2", 2, 16'h00E4);
    expect_reg("R1", 4, 16'h0000);
  endtask

  // R3, R7, R8: falling edge on line 1
  task automatic t_fall();
    irq_pin[1] = 1'b0;
    wait_n(2);
    expect_reg("R3", 4, 16'h0000);
    wait_n(1);
    expect_reg("R3", 4, 16'h0002);
    expect_irq("R8", 8'h02);
    irq_pin[1] = 1'b1;
    wait_n(4);
    expect_reg("R3", 4, 16'h0002);
    bus_write(4, 16'hFFFF);
    expect_reg("R7", 4, 16'h0002);
    bus_write(4, 16'hFFFD);
    expect_reg("R7", 4, 16'h0000);
    expect_irq("R8", 8'h00);
  endtask

  // R4: rising edge on line 2
  task automatic t_rise();
    irq_pin[2] = 1'b0;
    wait_n(4);
    expect_reg("R4", 4, 16'h0000);
    irq_pin[2] = 1'b1;
    wait_n(2);
    expect_reg("R4", 4, 16'h0000);
    wait_n(1);
    expect_reg("R4", 4, 16'h0004);
    bus_write(4, 16'hFFFB);
    expect_reg("R4", 4, 16'h0000);
  endtask

  // R5: both edges on line 3
  task automatic t_both();
    irq_pin[3] = 1'b0;
    wait_n(3);
    expect_reg("R5", 4, 16'h0008);
    bus_write(4, 16'hFFF7);
    expect_reg("R5", 4, 16'h0000);
    irq_pin[3] = 1'b1;
    wait_n(3);
    expect_reg("R5", 4, 16'h0008);
    expect_irq("R5", 8'h08);
    bus_write(4, 16'hFFF7);
    expect_reg("R5", 4, 16'h0000);
  endtask

  // R6: low level on line 0
  task automatic t_level();
    irq_pin[0] = 1'b0;
    wait_n(3);
    expect_reg("R6", 4, 16'h0001);
    bus_write(4, 16'hFFFE);
    expect_reg("R6", 4, 16'h0001);
    irq_pin[0] = 1'b1;
    wait_n(3);
    expect_reg("R6", 4, 16'h0001);
    bus_write(4, 16'hFFFE);
    expect_reg("R6", 4, 16'h0000);
    wait_n(2);
    expect_reg("R6", 4, 16'h0000);
  endtask

  // R7: several lines at once, partial clear
  task automatic t_multi();
    irq_pin[1] = 1'b0;
    irq_pin[2] = 1'b0;
    irq_pin[3] = 1'b0;
    wait_n(3);
    expect_reg("R7", 4, 16'h000A);
    bus_write(4, 16'hFFF7);
    expect_reg("R7", 4, 16'h0002);
    irq_pin[1] = 1'b1;
    irq_pin[2] = 1'b1;
    irq_pin[3] = 1'b1;
    wait_n(3);
    expect_reg("R7", 4, 16'h000E);
    expect_irq("R8", 8'h0E);
    bus_write(4, 16'hFF00);
    expect_reg("R7", 4, 16'h0000);
  endtask

  // R9, R10, R11: NMI with falling edge selected
  task automatic t_nmi_fall();
    nmi_pin = 1'b0;
    wait_n(1);
    expect_reg("R9", 0, 16'h8000);
    wait_n(1);
    expect_reg("R9", 0, 16'h0000);
    wait_n(1);
    expect_reg("R10", 0, 16'h0002);
    nmi_pin = 1'b1;
    wait_n(3);
    expect_reg("R10", 0, 16'h8002);
    bus_write(0, 16'h0002);
    expect_reg("R11", 0, 16'h8002);
    bus_write(0, 16'h0000);
    expect_reg("R11", 0, 16'h8000);
    bus_write(0, 16'h0002);
    expect_reg("R11", 0, 16'h8000);
  endtask

  // R10, R11: NMI rising edge, clear racing an event
  task automatic t_nmi_rise();
    bus_write(0, 16'h0100);
    expect_reg("R10", 0, 16'h8100);
    nmi_pin = 1'b0;
    wait_n(4);
    expect_reg("R10", 0, 16'h0100);
    nmi_pin = 1'b1;
    wait_n(3);
    expect_reg("R10", 0, 16'h8102);
    nmi_pin = 1'b0;
    wait_n(3);
    expect_reg("R10", 0, 16'h0102);
    nmi_pin = 1'b1;
    wait_n(2);
    bus_write(0, 16'h0100);
    expect_reg("R11", 0, 16'h8102);
    bus_write(0, 16'h0100);
    expect_reg("R11", 0, 16'h8100);
  endtask

  // R12: unmapped offsets and reserved bits
  task automatic t_unmapped();
    bus_write(6, 16'hFFFF);
    expect_reg("R12", 6, 16'h0000);
    bus_write(3, 16'h0000);
    expect_reg("R12", 2, 16'h00E4);
    expect_reg("R12", 5, 16'h0000);
    bus_write(0, 16'h0000);
    bus_write(0, 16'hFFFF);
    expect_reg("R12", 0, 16'h8100);
  endtask

  initial begin
    rst_n     = 1'b0;
    irq_pin   = 8'hFF;
    nmi_pin   = 1'b1;
    bus_addr  = 3'd0;
    bus_wen   = 1'b0;
    bus_wdata = 16'h0000;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_sense();
    t_fall();
    t_rise();
    t_both();
    t_level();
    t_multi();
    t_nmi_fall();
    t_nmi_rise();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule